// File: doc/BRIEF.md
# IDE Programmed-I/O Host Cycle Sequencer

This block sits on the host side of a parallel ATA link operated in its disk-compatible (True IDE) register mode. It accepts one request at a time: read or write, which of the two chip selects to use, a 3-bit register address and, for writes, the data word. It then runs one programmed-I/O bus cycle on the link. Each cycle has four parts:

- It presents the chip select and the address.
- It waits out a setup time.
- It pulls the read strobe or the write strobe low for a counted width.
- It keeps the address and any write data stable through a trailing phase.

When the trailing phase ends, the block pulses a completion flag. On a read, the returned word appears alongside that flag.

Each phase is timed in clock cycles. The cycle counts come from nanosecond minima and the clock period (in picoseconds), rounding up. Together the phases also meet the minimum length of a full bus cycle.

The width of each access follows from the decode. With the first chip select, address 0 is the 16-bit data register. Any other address is an 8-bit task-file register, and so is address 6 with the second chip select, which reads alternate status and writes device control.

Top module: `ide_pio_engine`

## Requirements
- R1: Out of reset both chip-select outputs are high, both strobes are high, the data bus is not driven, `reqReady` is 1 and `doneValid` is 0.
- R2: Chip select and address are valid for SETUP_CYC clock cycles (ceil(25 ns / period), 5 at 200 MHz) before the strobe falls.
- R3: The active strobe stays low for ACTIVE_CYC cycles: the larger of ceil(70 ns / period) and ceil(20 ns / period), which is 14 at 200 MHz. On writes, data is driven for the whole low time.
- R4: After the strobe rises, address, chip select and write data are held for TAIL_CYC cycles, and the strobes stay high. TAIL_CYC is the largest of the hold minima (10 ns), the remainder of the 120 ns cycle, and the 25 ns recovery minus setup; it is 5 at 200 MHz.
- R5: `doneValid` rises exactly SETUP_CYC+ACTIVE_CYC+TAIL_CYC cycles after the request is accepted. The chip selects are released at that point, so two accepted requests are at least 120 ns apart.
- R6: Read data is sampled on the clock edge that ends the last low cycle of the read strobe, and is returned on `doneRdata` with `doneValid`.
- R7: First chip select (`reqCsSel`=0) with address 0 transfers all 16 bits in both directions.
- R8: Every other register access is 8-bit. On a read, the upper byte of `doneRdata` is 0. On a write, the upper byte of `ideDataOut` is driven as 0.
- R9: `reqCsSel`=1 with address 6 asserts only `ideCs1N`, drives address 6, and is an 8-bit read (alternate status) or write (device control).
- R10: While a cycle is in progress, `reqReady` is 0 and any request on the input is ignored, so address and select stay at the accepted values.
- R11: `doneValid` is a single-cycle pulse per request.
- R12: At most one strobe is low at a time. A strobe is low only while exactly one chip select is low, and the data bus is driven only during writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCsSel | input | 1 | 0 = first chip select, 1 = second |
| reqAddr | input | 3 | Register address |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | Engine idle, request accepted this cycle if valid |
| doneValid | output | 1 | Cycle complete pulse |
| doneRdata | output | 16 | Read result, valid with doneValid |
| ideCs0N | output | 1 | First chip select, active low |
| ideCs1N | output | 1 | Second chip select, active low |
| ideAddr | output | 3 | Register address on the link |
| ideDiorN | output | 1 | Read strobe, active low |
| ideDiowN | output | 1 | Write strobe, active low |
| ideDataOut | output | 16 | Data driven toward the device |
| ideDataOe | output | 1 | Output enable for ideDataOut |
| ideDataIn | input | 16 | Data from the device |

## Verification
The bench changes the device data on every cycle and presents the correct word only in the final low cycle of the read strobe. A design that sampled one edge early or late would return the wrong word. Each phase is measured in half-cycle samples. A phase counter off by one would show up as a setup, strobe or tail length that is one cycle wrong, or as a completion pulse that arrives a cycle early or late. A conflicting request is held on the input throughout every transfer: an engine that took it in would change the address in mid-cycle or start an unwanted second cycle. Accesses through both chip selects at several addresses check the byte-width decode. An engine that got the decode wrong would leak the upper byte on an 8-bit register, or truncate the 16-bit data register.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_TAIL   = 2'd3
  } pioPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // latch request fields this edge
    logic selActive;  // chip select / address on the link
    logic rdStrobe;   // read strobe asserted
    logic wrStrobe;   // write strobe asserted
    logic driveData;  // write data on the bus
    logic capture;    // sample read data this edge
    logic finish;     // completion pulse
  } pioStrobes_t;

  function automatic int nsToCycles(input int ns, input int periodPs);
    return (ns * 1000 + periodPs - 1) / periodPs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ide_pio_ctrl.sv
module ide_pio_ctrl
  import ide_pio_pkg::*;
#(
  parameter int SETUP_CYC  = 5,
  parameter int ACTIVE_CYC = 14,
  parameter int TAIL_CYC   = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output pioStrobes_t strobes
);

  localparam int MAX_CYC = maxOf(SETUP_CYC, maxOf(ACTIVE_CYC, TAIL_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  pioPhase_t        phase;
  logic [CNT_W-1:0] cnt;
  logic             writeQ;
  logic             finishQ;
  logic             lastCyc;

  assign lastCyc = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      writeQ  <= 1'b0;
      finishQ <= 1'b0;
    end else begin
      finishQ <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            phase  <= PH_SETUP;
            cnt    <= CNT_W'(SETUP_CYC - 1);
            writeQ <= reqWrite;
          end
        end
        PH_SETUP: begin
          if (lastCyc) begin
            phase <= PH_ACTIVE;
            cnt   <= CNT_W'(ACTIVE_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_ACTIVE: begin
          if (lastCyc) begin
            phase <= PH_TAIL;
            cnt   <= CNT_W'(TAIL_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (lastCyc) begin
            phase   <= PH_IDLE;
            finishQ <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign reqReady = (phase == PH_IDLE);

  always_comb begin
    strobes           = '0;
    strobes.load      = (phase == PH_IDLE) && reqValid;
    strobes.selActive = (phase != PH_IDLE);
    strobes.rdStrobe  = (phase == PH_ACTIVE) && !writeQ;
    strobes.wrStrobe  = (phase == PH_ACTIVE) && writeQ;
    strobes.driveData = (phase != PH_IDLE) && writeQ;
    strobes.capture   = (phase == PH_ACTIVE) && lastCyc && !writeQ;
    strobes.finish    = finishQ;
  end

  // checker: length of each strobe-low run
  logic [CNT_W:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowRun <= '0;
    else if (phase == PH_ACTIVE) lowRun <= lowRun + 1'b1;
    else lowRun <= '0;
  end

  assert_active_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_TAIL && $past(phase) == PH_ACTIVE) |-> (lowRun == (CNT_W+1)'(ACTIVE_CYC)));

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.rdStrobe && strobes.wrStrobe));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    finishQ |=> !finishQ);

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load) |=> !reqReady);

endmodule

// File: rtl/ide_pio_dpath.sv
module ide_pio_dpath
  import ide_pio_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int BYTE_W        = 8,
  parameter int ADDR_W        = 3,
  parameter int DATA_REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  pioStrobes_t       strobes,
  input  logic              reqCsSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRdata,
  output logic              ideCs0N,
  output logic              ideCs1N,
  output logic [ADDR_W-1:0] ideAddr,
  output logic              ideDiorN,
  output logic              ideDiowN,
  output logic [DATA_W-1:0] ideDataOut,
  output logic              ideDataOe,
  input  logic [DATA_W-1:0] ideDataIn
);

  localparam int PAD_W = DATA_W - BYTE_W;

  logic              csSelQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              reqWide;

  // only the data register on the first select is full width
  assign reqWide = !reqCsSel && (reqAddr == ADDR_W'(DATA_REG_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSelQ <= 1'b0;
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobes.load) begin
      csSelQ <= reqCsSel;
      addrQ  <= reqAddr;
      wdataQ <= reqWide ? reqWdata : {{PAD_W{1'b0}}, reqWdata[BYTE_W-1:0]};
    end
  end

  logic wideQ;
  assign wideQ = !csSelQ && (addrQ == ADDR_W'(DATA_REG_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdataQ <= '0;
    else if (strobes.capture)
      rdataQ <= wideQ ? ideDataIn : {{PAD_W{1'b0}}, ideDataIn[BYTE_W-1:0]};
  end

  assign doneValid  = strobes.finish;
  assign doneRdata  = rdataQ;
  assign ideCs0N    = !(strobes.selActive && !csSelQ);
  assign ideCs1N    = !(strobes.selActive && csSelQ);
  assign ideAddr    = strobes.selActive ? addrQ : '0;
  assign ideDiorN   = !strobes.rdStrobe;
  assign ideDiowN   = !strobes.wrStrobe;
  assign ideDataOe  = strobes.driveData;
  assign ideDataOut = strobes.driveData ? wdataQ : '0;

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.selActive && $past(strobes.selActive)) |-> ($stable(ideAddr) && $stable(ideCs0N) && $stable(ideCs1N)));

  assert_wdata_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ideDataOe && $past(ideDataOe)) |-> $stable(ideDataOut));

  assert_strobe_one_sel_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!ideDiorN || !ideDiowN) |-> (ideCs0N ^ ideCs1N));

  assert_no_drive_on_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    !ideDiorN |-> !ideDataOe);

endmodule

// File: rtl/ide_pio_engine.sv
module ide_pio_engine
  import ide_pio_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 5000,
  parameter int SETUP_NS      = 25,
  parameter int ACTIVE_NS     = 70,
  parameter int RECOVERY_NS   = 25,
  parameter int WDATA_SU_NS   = 20,
  parameter int WDATA_HOLD_NS = 10,
  parameter int ADDR_HOLD_NS  = 10,
  parameter int CYCLE_NS      = 120,
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqCsSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRdata,
  output logic              ideCs0N,
  output logic              ideCs1N,
  output logic [ADDR_W-1:0] ideAddr,
  output logic              ideDiorN,
  output logic              ideDiowN,
  output logic [DATA_W-1:0] ideDataOut,
  output logic              ideDataOe,
  input  logic [DATA_W-1:0] ideDataIn
);

  localparam int SETUP_CYC  = maxOf(1, nsToCycles(SETUP_NS, CLK_PERIOD_PS));
  localparam int ACTIVE_CYC = maxOf(1, maxOf(nsToCycles(ACTIVE_NS, CLK_PERIOD_PS),
                                             nsToCycles(WDATA_SU_NS, CLK_PERIOD_PS)));
  localparam int CYCLE_CYC  = nsToCycles(CYCLE_NS, CLK_PERIOD_PS);
  localparam int HOLD_CYC   = maxOf(nsToCycles(ADDR_HOLD_NS, CLK_PERIOD_PS),
                                    nsToCycles(WDATA_HOLD_NS, CLK_PERIOD_PS));
  localparam int TAIL_CYC   = maxOf(1, maxOf(HOLD_CYC,
                                maxOf(CYCLE_CYC - SETUP_CYC - ACTIVE_CYC,
                                      nsToCycles(RECOVERY_NS, CLK_PERIOD_PS) - SETUP_CYC)));

  pioStrobes_t strobes;

  ide_pio_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .ACTIVE_CYC(ACTIVE_CYC),
    .TAIL_CYC  (TAIL_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobes (strobes)
  );

  ide_pio_dpath #(
    .DATA_W       (DATA_W),
    .BYTE_W       (8),
    .ADDR_W       (ADDR_W),
    .DATA_REG_ADDR(0)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqCsSel  (reqCsSel),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .doneValid (doneValid),
    .doneRdata (doneRdata),
    .ideCs0N   (ideCs0N),
    .ideCs1N   (ideCs1N),
    .ideAddr   (ideAddr),
    .ideDiorN  (ideDiorN),
    .ideDiowN  (ideDiowN),
    .ideDataOut(ideDataOut),
    .ideDataOe (ideDataOe),
    .ideDataIn (ideDataIn)
  );

endmodule

// File: tb/sim_ide_pio_engine.sv
`timescale 1ns/1ps
module sim_ide_pio_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqCsSel = 1'b0;
  logic [2:0]  reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        reqReady, doneValid;
  logic [15:0] doneRdata;
  logic        ideCs0N, ideCs1N, ideDiorN, ideDiowN, ideDataOe;
  logic [2:0]  ideAddr;
  logic [15:0] ideDataOut;
  logic [15:0] ideDataIn = 16'hDEAD;

  int nChecks = 0;
  int nFails  = 0;
  bit summaryDone = 0;

  always #2.5 clk = ~clk;

  ide_pio_engine u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCsSel(reqCsSel), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .doneValid(doneValid), .doneRdata(doneRdata),
    .ideCs0N(ideCs0N), .ideCs1N(ideCs1N), .ideAddr(ideAddr),
    .ideDiorN(ideDiorN), .ideDiowN(ideDiowN), .ideDataOut(ideDataOut),
    .ideDataOe(ideDataOe), .ideDataIn(ideDataIn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one bus transfer with per-half-cycle observation (timing at 200 MHz)
  task automatic runXfer(input bit wr, input bit sel, input logic [2:0] a,
                         input logic [15:0] wd, input logic [15:0] dev,
                         input logic [15:0] expRd, input logic [15:0] expOut,
                         input string tag);
    int firstLow = -1, lowCnt = 0, setupCnt = 0, tailCnt = 0;
    int doneAt = -1, extraDone = 0, badSel = 0, readyBusy = 0;
    int bothLow = 0, badData = 0, idleBad = 0;
    logic [15:0] gotRd = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqCsSel = sel; reqAddr = a; reqWdata = wd;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (k == 1) begin  // conflicting request held while busy (R10)
        reqAddr = ~a; reqWrite = ~wr; reqCsSel = ~sel; reqWdata = 16'h5A5A;
      end
      if (k == 24) reqValid = 1'b0;
      ideDataIn = (k == 19) ? dev : (16'hDEAD ^ 16'(k));
      #0.1;
      if (k <= 24) begin
        if (sel ? (ideCs1N || !ideCs0N) : (ideCs0N || !ideCs1N)) badSel++;
        if (ideAddr != a) badSel++;
        if (reqReady) readyBusy++;
        if (wr && (!ideDataOe || ideDataOut != expOut)) badData++;
      end else if (!ideCs0N || !ideCs1N) idleBad++;
      if (!wr && ideDataOe) badData++;
      if (wr ? !ideDiorN : !ideDiowN) bothLow++;
      if (wr ? !ideDiowN : !ideDiorN) begin
        lowCnt++;
        if (firstLow < 0) firstLow = k;
      end else if (k <= 24) begin
        if (firstLow < 0) setupCnt++;
        else tailCnt++;
      end
      if (doneValid) begin
        if (doneAt < 0) begin doneAt = k; gotRd = doneRdata; end
        else extraDone++;
      end
    end
    check(setupCnt == 5 && firstLow == 6, "R2", {tag, " setup cycles"}, setupCnt, 5);
    check(lowCnt == 14, "R3", {tag, " strobe low cycles"}, lowCnt, 14);
    check(tailCnt == 5, "R4", {tag, " trailing hold cycles"}, tailCnt, 5);
    check(doneAt == 25, "R5", {tag, " done position"}, doneAt, 25);
    check(extraDone == 0, "R11", {tag, " extra done pulses"}, extraDone, 0);
    check(badSel == 0, "R10", {tag, " select/address changed or wrong"}, badSel, 0);
    check(readyBusy == 0 && idleBad == 0, "R10", {tag, " busy ready / stray cycle"},
          readyBusy + idleBad, 0);
    check(bothLow == 0, "R12", {tag, " wrong strobe low"}, bothLow, 0);
    check(badData == 0, "R12", {tag, " data drive mismatches"}, badData, 0);
    if (!wr) check(gotRd == expRd, "R6", {tag, " read data"}, gotRd, expRd);
  endtask

  task automatic testReset();
    check(ideCs0N && ideCs1N, "R1", "chip selects after reset", {ideCs0N, ideCs1N}, 3);
    check(ideDiorN && ideDiowN, "R1", "strobes after reset", {ideDiorN, ideDiowN}, 3);
    check(!ideDataOe && reqReady && !doneValid, "R1", "oe/ready/done after reset",
          {ideDataOe, reqReady, doneValid}, 3'b010);
  endtask

  task automatic testDataRead();   // R7 16-bit read
    runXfer(1'b0, 1'b0, 3'd0, 16'h0, 16'hBEEF, 16'hBEEF, 16'h0, "R7 data read");
  endtask

  task automatic testDataWrite();  // R7 16-bit write
    runXfer(1'b1, 1'b0, 3'd0, 16'h1234, 16'h0, 16'h0, 16'h1234, "R7 data write");
  endtask

  task automatic testRegRead();    // R8 upper byte cleared
    runXfer(1'b0, 1'b0, 3'd7, 16'h0, 16'hA5C3, 16'h00C3, 16'h0, "R8 reg read");
  endtask

  task automatic testRegWrite();   // R8 upper byte driven zero
    runXfer(1'b1, 1'b0, 3'd2, 16'hFF3C, 16'h0, 16'h0, 16'h003C, "R8 reg write");
  endtask

  task automatic testAltStatus();  // R9 second select read
    runXfer(1'b0, 1'b1, 3'd6, 16'h0, 16'h1250, 16'h0050, 16'h0, "R9 alt status");
  endtask

  task automatic testDevCtl();     // R9 second select write
    runXfer(1'b1, 1'b1, 3'd6, 16'h7706, 16'h0, 16'h0, 16'h0006, "R9 device control");
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.1;
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testDataRead();
    testDataWrite();
    testRegRead();
    testRegWrite();
    testAltStatus();
    testDevCtl();
    repeat (3) @(negedge clk);
    finishRun();
  end

  initial begin
    #(5.0 * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

endmodule